// File: doc/BRIEF.md
# Oversampled LIN Byte Receiver

This block turns the single-wire LIN receive line into parallel bytes. A programmable divider derives an oversampling tick at sixteen times the bit rate from the system clock, and the line, after a two-flop synchronizer, is sampled on each tick into a sixteen-sample sliding window. A majority vote over that window gives a cleaned line level. Spikes are rejected, and the cost is a delay of about half a bit.

The frame logic around the block watches the cleaned line. When it sees the falling edge of a start bit, it pulses a restart strobe. That strobe resets the bit-phase counter, so each later bit is sampled near its centre, and it starts a fresh byte: start bit, eight data bits least significant first, stop bit. When the stop bit has been sampled, the byte appears on the data output together with a one-cycle done pulse and a framing flag. A separate counter flags a break when the cleaned line has been low for eleven bit times or more.

Top module: `lin_rx`

## Requirements
- R1: The oversampling tick fires once every D system clocks, where D = {div_hi_i, div_lo_i}. Divisor values 0 and 1 act as 2, so two ticks are never adjacent.
- R2: line_o is 1 when at least 8 of the last 16 tick samples of the synchronized rxd_i are 1, and 0 otherwise. line_o changes only in the cycle after a tick. Reset fills the window with ones, so line_o is 1 straight after reset whatever rxd_i is doing.
- R3: After restart_i, the bit sample is taken on the 8th tick and then on every 16th tick after that. The stop-bit sample, and so done_o, falls on the 152nd tick after the restart.
- R4: data_o takes the eight data-bit samples, with the first one received placed at bit 0. data_o changes only together with done_o.
- R5: done_o is a single-cycle pulse, given exactly once per completed byte.
- R6: ferr_o is set to 1 when the sampled stop bit is 0 and to 0 when it is 1. It is updated only with done_o and holds its value between bytes.
- R7: brk_o rises once line_o has stayed low for 176 ticks (11 bit times). It falls within one cycle of line_o returning high. A run of 9 low bits does not set it.
- R8: A restart_i that arrives while a byte is still in progress drops the partial byte with no done_o. Reception then starts again from the start bit.
- R9: Without a restart_i, the block produces no done_o, even if the line carries low levels or a break.
- R10: A low pulse on rxd_i that lasts 6 ticks leaves line_o at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Receive line from the transceiver (1 = recessive) |
| div_hi_i | input | DIV_W/2 | Upper half of the tick divisor |
| div_lo_i | input | DIV_W/2 | Lower half of the tick divisor |
| restart_i | input | 1 | Synchronous strobe: realign bit phase and begin a byte |
| line_o | output | 1 | Majority-filtered line level |
| data_o | output | 8 | Last received byte |
| done_o | output | 1 | One-cycle pulse when a byte completes |
| ferr_o | output | 1 | Stop bit of the last byte was 0 |
| brk_o | output | 1 | Line low for at least 11 bit times |

## Verification
If the window count drifts away from the window contents, line_o switches at the wrong number of low samples. That shows up within one bit time in the filter-delay and spike checks. A phase or bit-index counter that is off by one moves done_o outside the window of clocks allowed after restart_i, or shifts the data bits, so the error is visible at the end of the affected byte. A break counter limit that is wrong shows up as brk_o raised after a nine-bit low run, or still low after thirteen bits.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;
  localparam int unsigned OSR_DEF   = 16;
  localparam int unsigned NBIT_DEF  = 8;
  localparam int unsigned BRK_DEF   = 11;
  localparam int unsigned DIVW_DEF  = 16;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;
endpackage

// File: rtl/lin_rx_tick.sv
module lin_rx_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // divisors below 2 are clamped to 2
  always_comb lim = (div_i < DIV_W'(2)) ? DIV_W'(1) : div_i - DIV_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= lim) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
      tick_o <= 1'b0;
    end
  end

  assert_tick_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/lin_rx_vote.sv
module lin_rx_vote #(
  parameter int unsigned WIN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rxd_i,
  output logic line_o
);
  localparam int unsigned CW   = $clog2(WIN + 1);
  localparam int unsigned HALF = WIN / 2;

  logic [1:0]     sync_q;
  logic [WIN-1:0] win_q;
  logic [CW-1:0]  ones_q;
  logic [CW-1:0]  ones_nx;
  logic           smp;

  assign smp = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  // running count of ones: add newest, drop oldest
  always_comb ones_nx = ones_q + CW'(smp) - CW'(win_q[WIN-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '1;
      ones_q <= CW'(WIN);
      line_o <= 1'b1;
    end else if (tick_i) begin
      win_q  <= {win_q[WIN-2:0], smp};
      ones_q <= ones_nx;
      line_o <= (ones_nx >= CW'(HALF));
    end
  end

  assert_count_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= CW'(WIN));
  assert_count_track_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(win_q) == int'(ones_q));
  assert_line_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(line_o));
endmodule

// File: rtl/lin_rx_shift.sv
module lin_rx_shift
  import lin_rx_pkg::*;
#(
  parameter int unsigned OSR  = 16,
  parameter int unsigned NBIT = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            restart_i,
  input  logic            line_i,
  output logic [NBIT-1:0] data_o,
  output logic            done_o,
  output logic            ferr_o
);
  localparam int unsigned PW   = $clog2(OSR);
  localparam int unsigned LAST = NBIT + 1;
  localparam int unsigned IW   = $clog2(LAST + 1);
  localparam logic [PW-1:0] MID = PW'(OSR / 2 - 1);

  rx_state_e       st_q;
  logic [PW-1:0]   phase_q;
  logic [IW-1:0]   idx_q;
  logic [NBIT-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      phase_q <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      data_o  <= '0;
      done_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (restart_i) begin
        st_q    <= RX_BUSY;
        phase_q <= '0;
        idx_q   <= '0;
      end else if (st_q == RX_BUSY && tick_i) begin
        phase_q <= phase_q + PW'(1);
        if (phase_q == MID) begin
          if (idx_q == IW'(LAST)) begin
            st_q   <= RX_IDLE;
            done_o <= 1'b1;
            ferr_o <= ~line_i;
            data_o <= sh_q;
          end else begin
            // start bit sample (idx 0) is not stored
            if (idx_q != '0) sh_q <= {line_i, sh_q[NBIT-1:1]};
            idx_q <= idx_q + IW'(1);
          end
        end
      end
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_from_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(st_q == RX_BUSY));
  assert_data_at_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> done_o);
  assert_ferr_at_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ferr_o) |-> done_o);
  assert_restart_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !done_o);
endmodule

// File: rtl/lin_rx_brk.sv
module lin_rx_brk #(
  parameter int unsigned OSR      = 16,
  parameter int unsigned BRK_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  output logic brk_o
);
  localparam int unsigned LIM = OSR * BRK_BITS;
  localparam int unsigned CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      brk_o <= 1'b0;
    end else begin
      if (line_i)                         cnt_q <= '0;
      else if (tick_i && cnt_q != CW'(LIM)) cnt_q <= cnt_q + CW'(1);
      brk_o <= !line_i && (cnt_q == CW'(LIM));
    end
  end

  assert_brk_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> !$past(line_i));
  assert_brk_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_o) |-> $past(cnt_q == CW'(LIM)));
endmodule

// File: rtl/lin_rx.sv
module lin_rx
  import lin_rx_pkg::*;
#(
  parameter int unsigned DIV_W    = DIVW_DEF,
  parameter int unsigned OSR      = OSR_DEF,
  parameter int unsigned NBIT     = NBIT_DEF,
  parameter int unsigned BRK_BITS = BRK_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rxd_i,
  input  logic [DIV_W/2-1:0] div_hi_i,
  input  logic [DIV_W/2-1:0] div_lo_i,
  input  logic               restart_i,
  output logic               line_o,
  output logic [NBIT-1:0]    data_o,
  output logic               done_o,
  output logic               ferr_o,
  output logic               brk_o
);
  logic [DIV_W-1:0] div;
  logic             tick;

  assign div = {div_hi_i, div_lo_i};

  lin_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .div_i(div), .tick_o(tick)
  );

  lin_rx_vote #(.WIN(OSR)) u_vote (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick), .rxd_i(rxd_i), .line_o(line_o)
  );

  lin_rx_shift #(.OSR(OSR), .NBIT(NBIT)) u_shift (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick), .restart_i(restart_i),
    .line_i(line_o), .data_o(data_o), .done_o(done_o), .ferr_o(ferr_o)
  );

  lin_rx_brk #(.OSR(OSR), .BRK_BITS(BRK_BITS)) u_brk (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick), .line_i(line_o), .brk_o(brk_o)
  );

  assert_brk_excl_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> !done_o || ferr_o);
endmodule

// File: tb/lin_rx_bench.sv
module lin_rx_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rxd = 1'b0;
  logic [7:0] div_hi = 8'd0;
  logic [7:0] div_lo = 8'd4;
  logic       restart = 1'b0;
  logic       line_o, done_o, ferr_o, brk_o;
  logic [7:0] data_o;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int rs_cnt = 0;
  int done_time = 0;
  logic [7:0] got_data = 8'h00;
  logic       got_ferr = 1'b0;

  always #5 clk = ~clk;

  lin_rx u_lin_rx (
    .clk_i(clk), .rst_ni(rst_ni), .rxd_i(rxd), .div_hi_i(div_hi), .div_lo_i(div_lo),
    .restart_i(restart), .line_o(line_o), .data_o(data_o), .done_o(done_o),
    .ferr_o(ferr_o), .brk_o(brk_o)
  );

  // registered outputs read at the edge hold the previous cycle's values
  always @(posedge clk) begin
    if (restart) rs_cnt <= 0;
    else         rs_cnt <= rs_cnt + 1;
    if (done_o) begin
      done_cnt  <= done_cnt + 1;
      done_time <= rs_cnt;
      got_data  <= data_o;
      got_ferr  <= ferr_o;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic stop, input int bitc);
    logic [9:0] frame;
    frame = {stop, d, 1'b0};
    fork
      begin
        for (int i = 0; i < 10; i++) begin
          rxd = frame[i];
          wait_clk(bitc);
        end
        rxd = 1'b1;
        wait_clk(3 * bitc);
      end
      begin
        @(negedge clk);
        while (line_o) @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
      end
    join
  endtask

  // {divisor, data, stop bit}
  localparam int NVEC = 8;
  localparam logic [24:0] VEC [NVEC] = '{
    {16'd4, 8'h55, 1'b1},
    {16'd4, 8'h00, 1'b1},
    {16'd4, 8'hFF, 1'b1},
    {16'd6, 8'hA3, 1'b1},
    {16'd0, 8'h3C, 1'b1},
    {16'd1, 8'h96, 1'b1},
    {16'd4, 8'h80, 1'b0},
    {16'd4, 8'h01, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int prev;
    int d;
    int lo_seen;
    // reset with the line held low: window must still read idle (R2)
    wait_clk(4);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(line_o == 1'b1, "R2", "line after reset", line_o, 1);
    chk(done_o == 1'b0, "R5", "done after reset", done_o, 0);
    chk(brk_o == 1'b0, "R7", "break after reset", brk_o, 0);
    chk(ferr_o == 1'b0, "R6", "ferr after reset", ferr_o, 0);
    chk(data_o == 8'h00, "R4", "data after reset", data_o, 0);
    rxd = 1'b1;
    wait_clk(200);

    // vector walk
    for (int v = 0; v < NVEC; v++) begin
      {div_hi, div_lo} = VEC[v][24:9];
      d = (VEC[v][24:9] < 2) ? 2 : int'(VEC[v][24:9]);
      wait_clk(16 * d * 2);
      prev = done_cnt;
      send_byte(VEC[v][8:1], VEC[v][0], 16 * d);
      chk(done_cnt == prev + 1, "R5", "done count", done_cnt - prev, 1);
      chk(got_data == VEC[v][8:1], "R4", "data", got_data, VEC[v][8:1]);
      chk(got_ferr == !VEC[v][0], "R6", "framing flag", got_ferr, !VEC[v][0]);
      chk(done_time >= 151 * d + 1 && done_time <= 152 * d, "R3",
          "clocks restart to done", done_time, 152 * d);
      chk(done_time <= 152 * d, "R1", "tick rate", done_time, 152 * d);
    end
    div_hi = 8'd0;
    div_lo = 8'd4;
    wait_clk(200);

    // filter delay R2: fall needs 9 low samples
    @(negedge clk);
    rxd = 1'b0;
    wait_clk(28);
    chk(line_o == 1'b1, "R2", "line after 7 low ticks", line_o, 1);
    wait_clk(28);
    chk(line_o == 1'b0, "R2", "line after 14 low ticks", line_o, 0);
    rxd = 1'b1;
    wait_clk(128);
    chk(line_o == 1'b1, "R2", "line back high", line_o, 1);

    // spike rejection R10
    prev = done_cnt;
    rxd = 1'b0;
    wait_clk(24);
    rxd = 1'b1;
    lo_seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!line_o) lo_seen = 1;
    end
    chk(lo_seen == 0, "R10", "spike reached line", lo_seen, 0);

    // break R7 and no done without restart R9
    rxd = 1'b0;
    wait_clk(576);
    chk(brk_o == 1'b0, "R7", "break after 9 bits", brk_o, 0);
    wait_clk(256);
    chk(brk_o == 1'b1, "R7", "break after 13 bits", brk_o, 1);
    rxd = 1'b1;
    wait_clk(64);
    chk(brk_o == 1'b0, "R7", "break after release", brk_o, 0);
    wait_clk(700);
    chk(done_cnt == prev, "R9", "done without restart", done_cnt - prev, 0);

    // abort R8: partial byte then full byte
    prev = done_cnt;
    fork
      begin
        rxd = 1'b0;
        wait_clk(256);
        rxd = 1'b1;
        wait_clk(64);
      end
      begin
        @(negedge clk);
        while (line_o) @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
      end
    join
    send_byte(8'h5A, 1'b1, 64);
    chk(done_cnt == prev + 1, "R8", "dones after abort", done_cnt - prev, 1);
    chk(got_data == 8'h5A, "R8", "data after abort", got_data, 8'h5A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule